// File: doc/BRIEF.md
# Self-starting five-state counter

A synchronous 3-bit counter that follows a fixed, non-binary cycle of five codes. It advances one step on each rising clock edge while the count enable is high. The state bits are named C (most significant), B and A (least significant). Each bit is held in its own toggle flop. Combinational toggle equations decide which bits flip.

Three of the eight codes lie outside the cycle. If the counter powers up in one of them, or is loaded into one, it moves back into the cycle within two enabled edges and needs no reset to do so. A load port forces any code into the state register. It is used to place the counter in an unused code and watch it recover.

Top module: `seq5_counter`

## Requirements
- R1: When rst_ni is low the state becomes 000 at once, without waiting for a clock edge. Reset takes priority over load and enable.
- R2: With en_i high and load_i low, each rising edge moves state_o through the cycle 000, 010, 011, 101, 110 and back to 000.
- R3: With en_i and load_i both low, state_o keeps its value across clock edges, whether that value is a cycle code or an unused code.
- R4: An enabled edge from the unused code 100 gives 011.
- R5: An enabled edge from the unused code 001 gives 111.
- R6: An enabled edge from the unused code 111 gives 101.
- R7: Starting from any unused code, enabled edges reach a cycle code within two edges. A step from an unused code lands either in the cycle or on 111.
- R8: With load_i high, the next rising edge copies load_val_i into state_o, whatever the value of en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the state to 000 |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Force load of load_val_i on the next edge |
| load_val_i | input | 3 | Code to load (bit 2 = C, bit 0 = A) |
| state_o | output | 3 | Present state (bit 2 = C, bit 0 = A) |

## Verification
The unused codes 001, 100 and 111 cannot be reached from reset through normal counting. The bench therefore places each of them with the load port, and for each one it first checks that the code is held while the enable is low. It then applies single enabled edges, checking the exact successor after each edge and checking that the cycle is reached within two edges. The chain 001 → 111 → 101 is the longest recovery path, and it is checked edge by edge.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;
  localparam int unsigned IDX_C = 2;
  typedef logic [STATE_W-1:0] code_t;
  localparam code_t RESET_CODE = 3'b000;
endpackage

// File: rtl/seq5_toggle_logic.sv
module seq5_toggle_logic
  import seq5_pkg::*;
(
  input  code_t q_i,
  input  logic  en_i,
  output code_t tog_o
);
  logic a, b, c;
  code_t t;

  assign a = q_i[IDX_A];
  assign b = q_i[IDX_B];
  assign c = q_i[IDX_C];

  always_comb begin
    t        = '0;
    t[IDX_C] = a ^ c;
    t[IDX_B] = a | ~b | c;
    t[IDX_A] = (~a & b & ~c) | (~b & c);
    tog_o    = en_i ? t : '0;
  end
endmodule

// File: rtl/seq5_tff.sv
module seq5_tff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_bit_i,
  input  logic tog_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST_VAL;
    else if (load_i)  q_o <= load_bit_i;
    else if (tog_i)   q_o <= ~q_o;
  end
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
  import seq5_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_val_i,
  output logic [STATE_W-1:0] state_o
);
  code_t q, tog;

  seq5_toggle_logic u_tog (
    .q_i   (q),
    .en_i  (en_i),
    .tog_o (tog)
  );

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    seq5_tff #(.RST_VAL(RESET_CODE[i])) u_ff (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_i),
      .load_bit_i (load_val_i[i]),
      .tog_i      (tog[i]),
      .q_o        (q[i])
    );
  end

  assign state_o = q;
endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk
  import seq5_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               load_i,
  input logic [STATE_W-1:0] load_val_i,
  input logic [STATE_W-1:0] state_o
);
  function automatic logic in_cycle(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) ||
           (s == 3'b101) || (s == 3'b110);
  endfunction

  function automatic logic [2:0] cyc_next(input logic [2:0] s);
    case (s)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  logic step;
  assign step = en_i && !load_i;

  // R1
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> state_o == 3'b000);

  p_cycle_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && in_cycle(state_o) |=> state_o == cyc_next($past(state_o)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(state_o));

  p_exit_100_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && state_o == 3'b100 |=> state_o == 3'b011);

  p_exit_001_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && state_o == 3'b001 |=> state_o == 3'b111);

  p_exit_111_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && state_o == 3'b111 |=> state_o == 3'b101);

  p_recover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !in_cycle(state_o) |=> in_cycle(state_o) || state_o == 3'b111);

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(load_val_i));
endmodule

bind seq5_counter seq5_counter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .state_o    (state_o)
);

// File: tb/sim_seq5_counter.sv
`timescale 1ns/1ps
module sim_seq5_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ld = 1'b0;
  logic [2:0] ld_val = 3'b000;
  logic [2:0] st;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seq5_counter u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .load_i     (ld),
    .load_val_i (ld_val),
    .state_o    (st)
  );

  function automatic logic [2:0] succ(input logic [2:0] s);
    case (s)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b100: return 3'b011;
      3'b001: return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic cyc(input logic [2:0] s);
    return s == 3'b000 || s == 3'b010 || s == 3'b011 || s == 3'b101 || s == 3'b110;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // inputs change at negedge; one posedge passes, sample at next negedge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_code(input logic [2:0] v);
    ld = 1'b1; ld_val = v; en = 1'b0;
    tick();
    ld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", st, 3'b000);
    rst_n = 1'b1;
    tick();
    check("R1", st, 3'b000);
  endtask

  task automatic t_cycle();
    logic [2:0] exp;
    exp = st;
    en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      exp = succ(exp);
      check("R2", st, exp);
    end
    en = 1'b0;
  endtask

  task automatic t_hold();
    load_code(3'b011);
    check("R8", st, 3'b011);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3", st, 3'b011);
    end
    load_code(3'b100);
    tick();
    check("R3", st, 3'b100);
  endtask

  task automatic t_unused(input logic [2:0] code, input string req);
    load_code(code);
    tick();
    check("R3", st, code);
    en = 1'b1;
    tick();
    check(req, st, succ(code));
    if (!cyc(st)) begin
      tick();
    end
    en = 1'b0;
    check("R7", {2'b00, cyc(st)}, 3'b001);
  endtask

  task automatic t_load_priority();
    en = 1'b1; ld = 1'b1; ld_val = 3'b110;
    tick();
    check("R8", st, 3'b110);
    ld_val = 3'b001;
    tick();
    check("R8", st, 3'b001);
    ld = 1'b0;
    tick();
    check("R5", st, 3'b111);
    en = 1'b0;
  endtask

  task automatic t_async_reset();
    load_code(3'b101);
    en = 1'b1; ld = 1'b1; ld_val = 3'b111;
    #3 rst_n = 1'b0;
    #1 check("R1", st, 3'b000);
    tick();
    check("R1", st, 3'b000);
    ld = 1'b0;
    rst_n = 1'b1;
    tick();
    check("R2", st, 3'b010);
    en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%b expected=%b", 1'b1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_cycle();
    t_hold();
    t_unused(3'b100, "R4");
    t_unused(3'b001, "R5");
    t_unused(3'b111, "R6");
    t_load_priority();
    t_async_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule